// File: doc/BRIEF.md
# Wakeup Pin Edge Detector with Sticky Flags

This block watches five external wakeup pins and one internal wakeup line while the chip sits in a deep power state. Each pin has its own enable bit and its own edge select. The internal line always reacts to a rising edge. An edge on an enabled line sets a sticky flag. The block drives a single wake request to the power controller for as long as any flag on an enabled line is set.

Firmware sets up the lines through an enable register and a polarity register. It reads the flags from a status register that writes cannot change. It clears flags only through a separate write-1-to-clear register. A flag left set keeps the wake request high, so an attempt to enter sleep returns at once. Clearing the flags must therefore be the last step before entry. All inputs arrive already synchronized to the block clock.

Top module: `wkp_detect`

## Requirements
- R1: After reset the enable, polarity and status registers all read zero, and wake_req_o is low.
- R2: Registers are selected by a 2-bit address: 0 is enable, 1 is polarity, 2 is status and 3 is clear. Reads of address 3 return zero. In the enable register, pins 0..4 sit at bits 0..4 and the internal line at bit 15. The polarity register holds only bits 0..4. Every other bit reads zero.
- R3: A pin with polarity bit 0 sets its status flag (bit i for pin i) on a low-to-high change between two successive clock samples. The flag is visible after the clock edge that samples the new level.
- R4: A pin with polarity bit 1 sets its flag only on a high-to-low change. The opposite edge leaves the flag unchanged.
- R5: A line whose enable bit is 0 when its edge is sampled never sets its flag.
- R6: The internal line sets status bit 15 on a rising edge when enable bit 15 is set.
- R7: A flag stays set until a write of 1 to the same bit of the clear register. Writing 0 to a clear bit has no effect.
- R8: If a clear of a line and a new qualifying edge on that line fall in the same cycle, the flag ends up set.
- R9: wake_req_o is high exactly when some status flag is set whose line is currently enabled. Disabling a line masks its flag but does not clear it.
- R10: Writes to the status register address change nothing.
- R11: At reset each line's previous sample is taken as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 5 | External wakeup pins, already synchronized |
| int_wake_i | input | 1 | Internal wakeup line, already synchronized |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| wake_req_o | output | 1 | Combined wake request to the power controller |

## Verification
The hardest case to reach from the ports is a clear write and a qualifying edge on the same line in the same cycle. To get there, the flag must already be set and the pin must already be back at the idle level. The stimulus first sets the flag with an edge, then returns the pin to idle, which does not count as an edge. On a single falling clock edge it then raises the pin and issues the clear write together. A long random phase with frequent writes to every address also produces many such collisions, as well as enable changes that coincide with edges. These are checked on every clock against a behavioural model.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

    typedef enum logic [1:0] {
        REG_ENABLE   = 2'd0,
        REG_POLARITY = 2'd1,
        REG_STATUS   = 2'd2,
        REG_CLEAR    = 2'd3
    } wkp_reg_e;

endpackage

// File: rtl/wkp_edge_det.sv
module wkp_edge_det #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample_i,
    input  logic [W-1:0] fall_sel_i,
    output logic [W-1:0] edge_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sample_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_line
        assign edge_o[g] = fall_sel_i[g] ? ( st_q.prev[g] & ~sample_i[g])
                                         : (~st_q.prev[g] &  sample_i[g]);
    end

endmodule

// File: rtl/wkp_flag_bank.sv
module wkp_flag_bank #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] flags_o,
    output logic         wake_o
);

    typedef struct packed {
        logic [W-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    // a new edge overrides a clear in the same cycle
    always_comb begin
        st_d       = st_q;
        st_d.flags = set_i | (st_q.flags & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign wake_o  = |(st_q.flags & en_i);

endmodule

// File: rtl/wkp_detect.sv
module wkp_detect
    import wkp_pkg::*;
#(
    parameter int unsigned NUM_PINS = 5,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned INT_POS  = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                int_wake_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [1:0]          rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                wake_req_o
);

    localparam int unsigned NUM_LINES = NUM_PINS + 1;
    localparam int unsigned INT_LINE  = NUM_PINS;

    typedef struct packed {
        logic [NUM_LINES-1:0] en;
        logic [NUM_PINS-1:0]  pol;
    } cfg_t;

    cfg_t                 cfg_d, cfg_q;
    wkp_reg_e             wsel, rsel;
    logic [NUM_LINES-1:0] wr_line;
    logic [NUM_LINES-1:0] sample_vec;
    logic [NUM_LINES-1:0] fall_vec;
    logic [NUM_LINES-1:0] edge_vec;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] flags;
    logic [DATA_W-1:0]    en_reg, pol_reg, stat_reg;

    assign wsel = wkp_reg_e'(wr_addr_i);
    assign rsel = wkp_reg_e'(rd_addr_i);

    // map line-ordered vectors to and from the register layout
    assign wr_line[NUM_PINS-1:0] = wr_data_i[NUM_PINS-1:0];
    assign wr_line[INT_LINE]     = wr_data_i[INT_POS];

    always_comb begin
        en_reg                    = '0;
        en_reg[NUM_PINS-1:0]      = cfg_q.en[NUM_PINS-1:0];
        en_reg[INT_POS]           = cfg_q.en[INT_LINE];
        pol_reg                   = '0;
        pol_reg[NUM_PINS-1:0]     = cfg_q.pol;
        stat_reg                  = '0;
        stat_reg[NUM_PINS-1:0]    = flags[NUM_PINS-1:0];
        stat_reg[INT_POS]         = flags[INT_LINE];
    end

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (wsel)
                REG_ENABLE:   cfg_d.en  = wr_line;
                REG_POLARITY: cfg_d.pol = wr_data_i[NUM_PINS-1:0];
                default:      cfg_d     = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign clr_vec    = (wr_en_i && wsel == REG_CLEAR) ? wr_line : '0;
    assign sample_vec = {int_wake_i, pin_i};
    assign fall_vec   = {1'b0, cfg_q.pol};

    wkp_edge_det #(.W(NUM_LINES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (sample_vec),
        .fall_sel_i (fall_vec),
        .edge_o     (edge_vec)
    );

    assign hit = edge_vec & cfg_q.en;

    wkp_flag_bank #(.W(NUM_LINES)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (hit),
        .clr_i   (clr_vec),
        .en_i    (cfg_q.en),
        .flags_o (flags),
        .wake_o  (wake_req_o)
    );

    always_comb begin
        case (rsel)
            REG_ENABLE:   rd_data_o = en_reg;
            REG_POLARITY: rd_data_o = pol_reg;
            REG_STATUS:   rd_data_o = stat_reg;
            default:      rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/wkp_detect_chk.sv
module wkp_detect_chk #(
    parameter int unsigned W = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] en_line,
    input logic [W-1:0] flags,
    input logic [W-1:0] hit,
    input logic [W-1:0] clr_vec,
    input logic         wake_req
);

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((flags & $past(hit)) == $past(hit))); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~hit) != '0) |=> ((flags & $past(clr_vec & ~hit)) == '0)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~clr_vec) != '0) |=>
        ((flags & $past(flags & ~clr_vec)) == $past(flags & ~clr_vec))); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~en_line) == '0) |=>
        ((flags & ~$past(flags) & ~$past(en_line)) == '0)); // R5

    AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (flags != '0)); // R9

endmodule

bind wkp_detect wkp_detect_chk #(.W(NUM_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_line  (cfg_q.en),
    .flags    (flags),
    .hit      (hit),
    .clr_vec  (clr_vec),
    .wake_req (wake_req_o)
);

// File: tb/wkp_detect_test.sv
`timescale 1ns/1ps
module wkp_detect_test;

    localparam logic [1:0] A_EN = 2'd0, A_POL = 2'd1, A_ST = 2'd2, A_CLR = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  pins = '0;
    logic        iw = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  wa = '0;
    logic [1:0]  ra = A_ST;
    logic [15:0] wd = '0;
    logic [15:0] rd;
    logic        wake;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    wkp_detect uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .int_wake_i(iw),
        .wr_en_i(wr), .wr_addr_i(wa), .wr_data_i(wd),
        .rd_addr_i(ra), .rd_data_o(rd), .wake_req_o(wake)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit [15:0] m_en, m_pol, m_flag;
    bit [5:0]  m_prev;

    always @(posedge clk) begin : model
        int bp;
        bit cur, fall, edg, setb, clrb;
        bit [15:0] nf;
        bit [15:0] exp_rd;
        if (!rst_n) begin
            m_en = 0; m_pol = 0; m_flag = 0; m_prev = 0;
        end else begin
            nf = m_flag;
            for (int i = 0; i < 6; i++) begin
                bp   = (i < 5) ? i : 15;
                cur  = (i < 5) ? pins[i] : iw;
                fall = (i < 5) ? m_pol[i] : 1'b0;
                edg  = fall ? (m_prev[i] && !cur) : (!m_prev[i] && cur);
                setb = edg && m_en[bp];
                clrb = wr && (wa == A_CLR) && wd[bp];
                nf[bp] = setb || (m_flag[bp] && !clrb);
                m_prev[i] = cur;
            end
            m_flag = nf;
            if (wr && wa == A_EN)  m_en  = wd & 16'h801F;
            if (wr && wa == A_POL) m_pol = wd & 16'h001F;
        end
        #5;
        if (rst_n) begin
            case (ra)
                A_EN:    exp_rd = m_en;
                A_POL:   exp_rd = m_pol;
                A_ST:    exp_rd = m_flag;
                default: exp_rd = 16'h0000;
            endcase
            chk("R2 model readback", rd, exp_rd);
            chk("R9 model wake", {15'd0, wake}, {15'd0, |(m_flag & m_en)});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        wr = 1'b1; wa = a; wd = d;
        @(negedge clk);
        wr = 1'b0; wd = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
        ra = a;
        #1;
        chk(tag, rd, exp);
        ra = A_ST;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd_chk("R1 status", A_ST, 16'h0000);
        rd_chk("R1 enable", A_EN, 16'h0000);
        rd_chk("R1 polarity", A_POL, 16'h0000);
        chk("R1 wake", {15'd0, wake}, 16'h0000);
        // R2 register layout
        wr_reg(A_EN, 16'hFFFF);
        rd_chk("R2 enable mask", A_EN, 16'h801F);
        wr_reg(A_POL, 16'hFFFF);
        rd_chk("R2 polarity mask", A_POL, 16'h001F);
        rd_chk("R2 clear reads zero", A_CLR, 16'h0000);
        wr_reg(A_POL, 16'h0000);
        // R3 rising edge
        pins[2] = 1'b1; cyc(1);
        rd_chk("R3 rising sets", A_ST, 16'h0004);
        chk("R3 wake", {15'd0, wake}, 16'h0001);
        // R4 falling polarity
        wr_reg(A_POL, 16'h0002);
        pins[1] = 1'b1; cyc(1);
        rd_chk("R4 rising ignored", A_ST, 16'h0004);
        pins[1] = 1'b0; cyc(1);
        rd_chk("R4 falling sets", A_ST, 16'h0006);
        // R7 write-1-to-clear
        wr_reg(A_CLR, 16'h0000);
        rd_chk("R7 zero write no effect", A_ST, 16'h0006);
        wr_reg(A_CLR, 16'h0004);
        rd_chk("R7 clear one bit", A_ST, 16'h0002);
        wr_reg(A_CLR, 16'h0002);
        chk("R7 wake after clear", {15'd0, wake}, 16'h0000);
        // R5 disabled line
        wr_reg(A_EN, 16'h8017);
        pins[3] = 1'b1; cyc(1);
        pins[3] = 1'b0; cyc(1);
        rd_chk("R5 disabled quiet", A_ST, 16'h0000);
        // R6 internal line
        iw = 1'b1; cyc(1);
        rd_chk("R6 internal sets", A_ST, 16'h8000);
        chk("R6 wake", {15'd0, wake}, 16'h0001);
        iw = 1'b0;
        wr_reg(A_CLR, 16'h8000);
        rd_chk("R6 internal cleared", A_ST, 16'h0000);
        // R8 set wins over clear
        pins[0] = 1'b1; cyc(1);
        rd_chk("R8 setup", A_ST, 16'h0001);
        pins[0] = 1'b0; cyc(1);
        pins[0] = 1'b1;
        wr_reg(A_CLR, 16'h0001);
        rd_chk("R8 set wins", A_ST, 16'h0001);
        wr_reg(A_CLR, 16'h0001);
        // R9 masking
        pins[4] = 1'b1; cyc(1);
        chk("R9 wake on flag", {15'd0, wake}, 16'h0001);
        wr_reg(A_EN, 16'h800F);
        chk("R9 masked wake", {15'd0, wake}, 16'h0000);
        rd_chk("R9 flag kept", A_ST, 16'h0010);
        wr_reg(A_EN, 16'h801F);
        chk("R9 unmasked wake", {15'd0, wake}, 16'h0001);
        wr_reg(A_CLR, 16'h0010);
        // R10 status writes ignored
        pins[2] = 1'b0; cyc(1);
        pins[2] = 1'b1; cyc(1);
        wr_reg(A_ST, 16'h0000);
        rd_chk("R10 status write zero", A_ST, 16'h0004);
        wr_reg(A_ST, 16'hFFFF);
        rd_chk("R10 status write ones", A_ST, 16'h0004);
        // R11: prior sample low at reset, pin held high across reset
        rst_n = 1'b0; cyc(2);
        rst_n = 1'b1;
        wr_reg(A_EN, 16'h0004);
        rd_chk("R11 no late edge", A_ST, 16'h0000);
        pins[2] = 1'b0; cyc(1);
        pins[2] = 1'b1; cyc(1);
        rd_chk("R11 edge after reset", A_ST, 16'h0004);
        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            pins = 5'($urandom);
            iw   = 1'($urandom);
            ra   = 2'($urandom);
            if ($urandom_range(0, 2) == 0) begin
                wr = 1'b1; wa = 2'($urandom); wd = 16'($urandom);
            end else begin
                wr = 1'b0;
            end
        end
        @(negedge clk);
        wr = 1'b0; ra = A_ST;
        cyc(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule